// File: doc/BRIEF.md
# 12-bit Coefficient Byte Packer

This block turns polynomials of 256 twelve-bit coefficients into a dense byte stream. Every two coefficients become three bytes. After a start pulse it walks through K polynomials in turn. K is chosen at start time and can be 2, 3 or 4. For each polynomial it reads coefficients from a coefficient memory that has one read port and one cycle of registered read latency. It writes the packed bytes to a byte memory, one byte per clock, at consecutive addresses starting at zero.

If the seed-append select is set at start, the block writes 32 seed bytes directly after the last polynomial byte. When the final byte has been written, the block raises a one-cycle done pulse. The block does not compute the coefficients and does no hashing. It is used after a polynomial-producing stage has filled the coefficient memory.

Top module: `coef_pack12`

## Requirements
- R1: While reset is held, and in the first cycle after it, the coefficient read enable, the byte write enable and the done output are all low.
- R2: For coefficient pair j of polynomial p, the block uses c0 at coefficient address 256*p+2j and c1 at 256*p+2j+1. It writes three bytes at 384*p+3j, 384*p+3j+1 and 384*p+3j+2, with these values:
  - the first byte is c0 bits 7..0;
  - the second byte is c1 bits 3..0 in bits 7..4 and c0 bits 11..8 in bits 3..0;
  - the third byte is c1 bits 11..4.
- R3: Each pair takes four cycles:
  - slot 0 reads c0;
  - slot 1 writes the first byte and reads c1;
  - slot 2 writes the second byte;
  - slot 3 writes the third byte.
  
  Slot 0 of the first pair is the first cycle after start is taken. At most one byte is written per cycle. Write addresses run 0, 1, 2 and so on without gaps. Coefficient read addresses run 0, 1, 2 and so on.
- R4: The K polynomials are encoded back to back with no idle cycles, giving 384*K polynomial bytes in total.
- R5: With seed append selected, seed byte i (seed input bits 8i+7..8i) is written at address 384*K+i for i = 0..31, right after the polynomial bytes. Without seed append, no byte is written beyond 384*K-1.
- R6: done is high for exactly one cycle, the cycle after the last byte write. It rises 512*K+32*s+1 cycles after the edge that took start, where s is 1 with seed append and 0 without.
- R7: A start while the block is busy, including the done cycle, is ignored. It changes neither the running output nor starts a new run.
- R8: A K value below 2 is treated as 2, and a value above 4 is treated as 4.
- R9: Coefficient bits are packed exactly as read, with no modular reduction. For example, 4095 yields all-ones bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| k_i | input | 3 | Number of polynomials, sampled at start |
| seed_en_i | input | 1 | Append seed bytes, sampled at start |
| seed_i | input | 256 | Seed bytes, byte i at bits 8i+7..8i, sampled at start |
| coef_rd_en_o | output | 1 | Coefficient memory read enable |
| coef_rd_addr_o | output | 10 | Coefficient memory read address |
| coef_rd_data_i | input | 12 | Coefficient read data, valid one cycle after the enable |
| byte_wr_en_o | output | 1 | Byte memory write enable |
| byte_wr_addr_o | output | 11 | Byte memory write address |
| byte_wr_data_o | output | 8 | Byte memory write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a run, or in the done cycle itself. In both cases the request must leave the byte stream and the timing untouched. The stimulus raises start with a different K partway through a K=4 run with seed append. It raises start again in the cycle where done is seen. It then watches the ports for idle cycles with no writes, reads or done. The full sweep covers every K, both seed settings, out-of-range K values, and coefficient patterns that include the values 0, 3328 and 4095. Each written byte is compared with a value computed from the packing rule.

// File: rtl/coef_pack12_pkg.sv
`timescale 1ns/1ps
package coef_pack12_pkg;
    localparam int CP_COEF_W     = 12;
    localparam int CP_N_COEF     = 256;
    localparam int CP_K_MIN      = 2;
    localparam int CP_K_MAX      = 4;
    localparam int CP_SEED_BYTES = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POLY = 2'd1,
        ST_SEED = 2'd2,
        ST_FIN  = 2'd3
    } cp_state_e;

    // Slot inside the four-cycle pair schedule.
    typedef enum logic [1:0] {
        PH_FETCH0 = 2'd0,
        PH_LOW    = 2'd1,
        PH_MID    = 2'd2,
        PH_HIGH   = 2'd3
    } cp_phase_e;
endpackage

// File: rtl/cp12_pack.sv
`timescale 1ns/1ps
// Forms the output byte for the current slot of a coefficient pair.
module cp12_pack
    import coef_pack12_pkg::*;
(
    input  cp_phase_e  phase_i,
    input  logic [11:0] rdata_i,
    input  logic [3:0]  c0_hi_i,
    input  logic [7:0]  c1_hi_i,
    output logic [7:0]  byte_o
);
    always_comb begin
        unique case (phase_i)
            PH_LOW:  byte_o = rdata_i[7:0];
            PH_MID:  byte_o = {rdata_i[3:0], c0_hi_i};
            PH_HIGH: byte_o = c1_hi_i;
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/cp12_seed_pick.sv
`timescale 1ns/1ps
// Selects one byte of the captured seed word.
module cp12_seed_pick #(
    parameter int SEED_BYTES = 32,
    localparam int SIDX_W    = (SEED_BYTES > 1) ? $clog2(SEED_BYTES) : 1
) (
    input  logic [SEED_BYTES*8-1:0] seed_i,
    input  logic [SIDX_W-1:0]       idx_i,
    output logic [7:0]              byte_o
);
    assign byte_o = seed_i[{idx_i, 3'b000} +: 8];
endmodule

// File: rtl/coef_pack12.sv
`timescale 1ns/1ps
module coef_pack12
    import coef_pack12_pkg::*;
#(
    parameter int N_COEF     = CP_N_COEF,
    parameter int K_MAX      = CP_K_MAX,
    parameter int SEED_BYTES = CP_SEED_BYTES,
    localparam int COEF_W    = CP_COEF_W,
    localparam int PAIRS     = N_COEF / 2,
    localparam int PAIR_W    = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int POLY_W    = (K_MAX > 1) ? $clog2(K_MAX) : 1,
    localparam int KW        = $clog2(K_MAX + 1),
    localparam int CADDR_W   = $clog2(K_MAX * N_COEF),
    localparam int POLY_BYTES = N_COEF * COEF_W / 8,
    localparam int BADDR_W   = $clog2(POLY_BYTES * K_MAX + SEED_BYTES),
    localparam int SIDX_W    = (SEED_BYTES > 1) ? $clog2(SEED_BYTES) : 1,
    localparam int SEED_BITS = SEED_BYTES * 8
) (
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    input  logic                 start_i,
    input  logic [KW-1:0]        k_i,
    input  logic                 seed_en_i,
    input  logic [SEED_BITS-1:0] seed_i,
    output logic                 coef_rd_en_o,
    output logic [CADDR_W-1:0]   coef_rd_addr_o,
    input  logic [COEF_W-1:0]    coef_rd_data_i,
    output logic                 byte_wr_en_o,
    output logic [BADDR_W-1:0]   byte_wr_addr_o,
    output logic [7:0]           byte_wr_data_o,
    output logic                 done_o
);
    typedef struct packed {
        cp_state_e            st;
        cp_phase_e            ph;
        logic [PAIR_W-1:0]    pair;
        logic [POLY_W-1:0]    poly;
        logic [KW-1:0]        k;
        logic                 seed_en;
        logic [SEED_BITS-1:0] seed;
        logic [BADDR_W-1:0]   bcnt;
        logic [SIDX_W-1:0]    sidx;
        logic [3:0]           c0_hi;
        logic [7:0]           c1_hi;
    } cp_regs_t;

    cp_regs_t   q, d;
    logic [7:0] pair_byte;
    logic [7:0] seed_byte;
    logic [KW-1:0] k_clamped;

    cp12_pack u_pack (
        .phase_i (q.ph),
        .rdata_i (coef_rd_data_i),
        .c0_hi_i (q.c0_hi),
        .c1_hi_i (q.c1_hi),
        .byte_o  (pair_byte)
    );

    cp12_seed_pick #(.SEED_BYTES(SEED_BYTES)) u_seed (
        .seed_i (q.seed),
        .idx_i  (q.sidx),
        .byte_o (seed_byte)
    );

    always_comb begin
        if (k_i < KW'(CP_K_MIN))      k_clamped = KW'(CP_K_MIN);
        else if (k_i > KW'(K_MAX))    k_clamped = KW'(K_MAX);
        else                          k_clamped = k_i;
    end

    always_comb begin
        d              = q;
        coef_rd_en_o   = 1'b0;
        coef_rd_addr_o = CADDR_W'(q.poly) * CADDR_W'(N_COEF)
                       + CADDR_W'({q.pair, q.ph[0]});
        byte_wr_en_o   = 1'b0;
        byte_wr_addr_o = q.bcnt;
        byte_wr_data_o = pair_byte;
        done_o         = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st      = ST_POLY;
                    d.ph      = PH_FETCH0;
                    d.pair    = '0;
                    d.poly    = '0;
                    d.k       = k_clamped;
                    d.seed_en = seed_en_i;
                    d.seed    = seed_i;
                    d.bcnt    = '0;
                    d.sidx    = '0;
                end
            end
            ST_POLY: begin
                d.ph = cp_phase_e'(q.ph + 2'd1);
                unique case (q.ph)
                    PH_FETCH0: coef_rd_en_o = 1'b1;
                    PH_LOW: begin
                        coef_rd_en_o = 1'b1;
                        byte_wr_en_o = 1'b1;
                        d.c0_hi      = coef_rd_data_i[11:8];
                    end
                    PH_MID: begin
                        byte_wr_en_o = 1'b1;
                        d.c1_hi      = coef_rd_data_i[11:4];
                    end
                    default: begin
                        byte_wr_en_o = 1'b1;
                        d.pair       = q.pair + PAIR_W'(1);
                        if (q.pair == PAIR_W'(PAIRS - 1)) begin
                            d.pair = '0;
                            if (q.poly == POLY_W'(q.k - KW'(1)))
                                d.st = q.seed_en ? ST_SEED : ST_FIN;
                            else
                                d.poly = q.poly + POLY_W'(1);
                        end
                    end
                endcase
            end
            ST_SEED: begin
                byte_wr_en_o   = 1'b1;
                byte_wr_data_o = seed_byte;
                d.sidx         = q.sidx + SIDX_W'(1);
                if (q.sidx == SIDX_W'(SEED_BYTES - 1))
                    d.st = ST_FIN;
            end
            default: begin
                done_o = 1'b1;
                d.st   = ST_IDLE;
            end
        endcase

        if (byte_wr_en_o)
            d.bcnt = q.bcnt + BADDR_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) q <= '0;
        else          q <= d;
    end
endmodule

// File: rtl/coef_pack12_chk.sv
`timescale 1ns/1ps
module coef_pack12_chk
    import coef_pack12_pkg::*;
#(
    localparam int CADDR_W = $clog2(CP_K_MAX * CP_N_COEF),
    localparam int BADDR_W = $clog2(CP_N_COEF * CP_COEF_W / 8 * CP_K_MAX + CP_SEED_BYTES),
    localparam int BYTE_LIMIT = CP_N_COEF * CP_COEF_W / 8 * CP_K_MAX + CP_SEED_BYTES
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [CADDR_W-1:0] rd_addr,
    input logic               wr_en,
    input logic [BADDR_W-1:0] wr_addr,
    input logic               done
);
    logic               seen_q;
    logic [BADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (done) begin
            seen_q <= 1'b0;
        end else if (wr_en) begin
            seen_q <= 1'b1;
            last_q <= wr_addr;
        end
    end

    // R3
    seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen_q) |-> (wr_addr == last_q + BADDR_W'(1)));

    // R3
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !seen_q) |-> (wr_addr == '0));

    // R2
    pair_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + CADDR_W'(1)));

    // R6
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && !wr_en));

    // R6
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < BYTE_LIMIT));
endmodule

bind coef_pack12 coef_pack12_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_n_i),
    .rd_en   (coef_rd_en_o),
    .rd_addr (coef_rd_addr_o),
    .wr_en   (byte_wr_en_o),
    .wr_addr (byte_wr_addr_o),
    .done    (done_o)
);

// File: tb/coef_pack12_bench.sv
`timescale 1ns/1ps
module coef_pack12_bench;
    localparam int NC    = 256;
    localparam int KM    = 4;
    localparam int SB    = 32;
    localparam int BYTES = 384 * KM + SB;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   k = 3'd0;
    logic         seed_en = 1'b0;
    logic [255:0] seed = '0;
    logic         rd_en;
    logic [9:0]   rd_addr;
    logic [11:0]  rdata;
    logic         wr_en;
    logic [10:0]  wr_addr;
    logic [7:0]   wr_data;
    logic         done;

    int         coef_mem [KM*NC];
    logic [7:0] cap [BYTES];
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rd_en) rdata <= 12'(coef_mem[rd_addr]);

    coef_pack12 u_coef_pack12 (
        .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .k_i(k),
        .seed_en_i(seed_en), .seed_i(seed),
        .coef_rd_en_o(rd_en), .coef_rd_addr_o(rd_addr), .coef_rd_data_i(rdata),
        .byte_wr_en_o(wr_en), .byte_wr_addr_o(wr_addr), .byte_wr_data_o(wr_data),
        .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pat(input int mode, input int idx);
        case (mode)
            0: return (idx * 1237 + 11) % 3329;
            1: return (idx % 2) ? 3328 : 0;
            2: return (idx % 3 == 0) ? 4095 : ((idx % 3 == 1) ? 0 : 2730);
            default: return (idx * idx + 5 * idx) % 3329;
        endcase
    endfunction

    function automatic int exp_byte(input int kk, input int a);
        int p, b, j, r, c0, c1;
        if (a < 384 * kk) begin
            p  = a / 384;
            b  = a % 384;
            j  = b / 3;
            r  = b % 3;
            c0 = coef_mem[p*NC + 2*j];
            c1 = coef_mem[p*NC + 2*j + 1];
            if (r == 0) return c0 & 255;
            if (r == 1) return ((c1 & 15) << 4) | (c0 >> 8);
            return c1 >> 4;
        end
        return int'(seed[(a - 384*kk)*8 +: 8]);
    endfunction

    task automatic run_case(input int kin, input int keff, input bit se,
                            input int mode, input bit poke, input string req);
        int n = 1;
        int done_n = -1;
        int last_wr = -1;
        int wr_cnt = 0;
        int next_addr = 0;
        int rd_next = 0;
        int addr_bad = 0;
        int rd_bad = 0;
        int slot_bad = 0;
        int poly_mis = 0;
        int seed_mis = 0;
        int stray = 0;
        int limit = 512 * KM + SB + 20;
        int exp_lat = 512 * keff + 32 * int'(se) + 1;
        for (int i = 0; i < KM*NC; i++) coef_mem[i] = pat(mode, i);
        for (int i = 0; i < BYTES; i++) cap[i] = 8'h00;
        @(negedge clk);
        for (int i = 0; i < SB; i++) seed[i*8 +: 8] = 8'(i * 29 + mode * 7 + 1);
        start = 1'b1; k = 3'(kin); seed_en = se;
        @(negedge clk);
        start = 1'b0;
        while (done_n < 0 && n <= limit) begin
            if (wr_en) begin
                if (int'(wr_addr) != next_addr) addr_bad++;
                if (int'(wr_addr) < BYTES) cap[wr_addr] = wr_data;
                next_addr++; wr_cnt++; last_wr = n;
                if (n <= 512 * keff && (n - 1) % 4 == 0) slot_bad++;
            end
            if (rd_en) begin
                if (int'(rd_addr) != rd_next) rd_bad++;
                rd_next++;
                if ((n - 1) % 4 > 1) slot_bad++;
            end
            if (done) done_n = n;
            if (poke && n == 100) begin start = 1'b1; k = (kin == 4) ? 3'd2 : 3'd4; end
            if (poke && n == 101) start = 1'b0;
            if (done_n < 0) begin @(negedge clk); n++; end
        end
        chk(done_n > 0, "R6", "done seen", done_n, exp_lat);
        if (done_n < 0) return;
        if (poke) begin start = 1'b1; k = 3'd3; end
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (wr_en || rd_en || done) stray++;
        end
        chk(done_n == exp_lat, "R6", "done latency", done_n, exp_lat);
        chk(done_n == last_wr + 1, "R6", "done after last write", done_n, last_wr + 1);
        chk(wr_cnt == 384 * keff + 32 * int'(se), se ? "R5" : "R4", "byte count",
            wr_cnt, 384 * keff + 32 * int'(se));
        chk(addr_bad == 0, "R3", "non-sequential write addresses", addr_bad, 0);
        chk(rd_bad == 0 && rd_next == NC * keff, "R3", "read address sequence",
            rd_next, NC * keff);
        chk(slot_bad == 0, "R3", "accesses outside their slot", slot_bad, 0);
        for (int a = 0; a < 384 * keff; a++)
            if (int'(cap[a]) != exp_byte(keff, a)) poly_mis++;
        chk(poly_mis == 0, req, "packed byte mismatches", poly_mis, 0);
        if (se) begin
            for (int a = 384 * keff; a < 384 * keff + SB; a++)
                if (int'(cap[a]) != exp_byte(keff, a)) seed_mis++;
            chk(seed_mis == 0, "R5", "seed byte mismatches", seed_mis, 0);
        end
        chk(stray == 0, poke ? "R7" : "R6", "activity after done", stray, 0);
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R1", "outputs in reset",
            int'({rd_en, wr_en, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R1", "outputs after reset",
            int'({rd_en, wr_en, done}), 0);
        run_case(2, 2, 1'b0, 0, 1'b0, "R2");
        run_case(3, 3, 1'b1, 3, 1'b0, "R2");
        run_case(4, 4, 1'b1, 0, 1'b1, "R7");
        run_case(2, 2, 1'b1, 2, 1'b0, "R9");
        run_case(4, 4, 1'b0, 1, 1'b0, "R9");
        run_case(0, 2, 1'b0, 3, 1'b0, "R8");
        run_case(1, 2, 1'b1, 0, 1'b0, "R8");
        run_case(7, 4, 1'b1, 3, 1'b0, "R8");
        run_case(3, 3, 1'b0, 2, 1'b1, "R4");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule